// File: doc/BRIEF.md
# Vector Register Remapping Unit

This unit translates a 5-bit architectural register number into a 6-bit physical register number, which opens a 64-register space for each register file. It holds two independent 32-entry tables, one for the integer file and one for the floating-point file. Each entry carries an enable bit, a vector bit, a 6-bit target index and a 2-bit element-width code. Entries are written through a single-cycle write port.

A lookup takes a register number, a file select and a 6-bit running loop offset. The unit returns the physical register, the offset to use for the next loop pass, a vector flag and a fault flag. A disabled entry passes the register number through unchanged. An enabled scalar entry redirects to its target, so a scalar entry can still reach the upper half of the doubled space. Only an enabled vector entry adds the loop offset to its target and advances that offset by one. The lookup is combinational, so the result is ready in the same cycle. The loop sequencing that feeds the offset back each cycle belongs to the caller.

Top module: `vreg_redirect`

## Requirements
- R1: The select input picks the table: 0 selects the integer table and 1 selects the floating-point table. A write to one table never changes a lookup in the other.
- R2: The stored target is 6 bits wide, and an enabled scalar entry can return any index from 0 to 63, including 63.
- R3: When the selected entry's enable bit is 0, the physical register equals the lookup register zero-extended to 6 bits, the returned offset equals the incoming offset, and the vector flag is 0.
- R4: When the entry is enabled and its vector bit is 0, the physical register equals the stored target and the returned offset equals the incoming offset.
- R5: When the entry is enabled and its vector bit is 1, the physical register is the stored target plus the incoming offset, and the returned offset is the incoming offset plus one.
- R6: The vector flag is 1 only when the selected entry is both enabled and marked vector.
- R7: The fault flag is 1 whenever the selected entry's element-width code is nonzero, whether or not the entry is enabled.
- R8: The target-plus-offset sum and the offset increment both wrap modulo 64. For example, 62+5 gives 3, and an offset of 63 advances to 0.
- R9: A table write takes effect at the next rising clock edge. A synchronous active-low reset clears every field of every entry, so that all lookups pass through.
- R10: The lookup is combinational. A lookup of an entry that is being written in the same cycle returns the entry's old contents until the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_fp | input | 1 | Write target table: 0 integer, 1 floating point |
| wr_addr | input | 5 | Entry being written |
| wr_active | input | 1 | Enable bit to store |
| wr_vector | input | 1 | Vector bit to store |
| wr_target | input | 6 | Target index to store |
| wr_ewidth | input | 2 | Element-width code to store |
| lk_fp | input | 1 | Lookup table: 0 integer, 1 floating point |
| lk_reg | input | 5 | Architectural register to translate |
| lk_offs | input | 6 | Incoming loop offset |
| phys_reg | output | 6 | Translated physical register |
| offs_next | output | 6 | Loop offset for the next pass |
| is_vec | output | 1 | Entry is enabled and marked vector |
| elw_fault | output | 1 | Element-width code is nonzero |

## Verification
A table write and a lookup of the very same entry can land in one cycle. The bench provokes this by driving both on the same falling edge for one integer entry. The bench samples the result before the rising edge and expects the old pass-through value. After the edge it samples again and expects the new redirected target. A second collision writes one table while the other table is being read, and the bench judges that the read is unaffected.

// File: rtl/vrr_pkg.sv
// Package: shared widths and the table entry layout for the remapping unit.
// Assumes two register files, each addressed by a 5-bit architectural number.
package vrr_pkg;
    localparam int ARCH_W   = 5;
    localparam int PHYS_W   = 6;
    localparam int EW_W     = 2;
    localparam int ENTRIES  = 1 << ARCH_W;
    localparam int FILE_CNT = 2;

    typedef struct packed {
        logic              active;
        logic              vector;
        logic [PHYS_W-1:0] target;
        logic [EW_W-1:0]   ewidth;
    } map_entry_t;
endpackage

// File: rtl/vrr_entry_bank.sv
// Module: one remap table of ENTRIES entries with one write and one read port.
// Assumes the write lands on the clock edge and the read is asynchronous,
// so a same-cycle read of the entry being written sees the old contents.
module vrr_entry_bank
    import vrr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_addr,
    input  map_entry_t        wr_data,
    input  logic [ARCH_W-1:0] rd_addr,
    output map_entry_t        rd_data
);
    map_entry_t mem [ENTRIES];

    // Store a written entry, or clear all of them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the addressed entry to the lookup path.
    always_comb begin
        rd_data = mem[rd_addr];
    end

    // A written entry holds the written contents one edge later.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/vrr_resolve.sv
// Module: combinational translation of one table entry into the physical
// register, the next loop offset and the status flags.
// Assumes the sum and the increment wrap at PHYS_W bits.
module vrr_resolve
    import vrr_pkg::*;
(
    input  map_entry_t        entry,
    input  logic [ARCH_W-1:0] arch_reg,
    input  logic [PHYS_W-1:0] offs_in,
    output logic [PHYS_W-1:0] phys_out,
    output logic [PHYS_W-1:0] offs_out,
    output logic              vec_out,
    output logic              fault_out
);
    logic [PHYS_W-1:0] base;
    logic              stepping;

    // Choose the pass-through number or the stored target.
    always_comb begin
        base = entry.active ? entry.target : PHYS_W'(arch_reg);
    end

    // Only an enabled vector entry adds and advances the offset.
    always_comb begin
        stepping = entry.active && entry.vector;
        phys_out = stepping ? (base + offs_in) : base;
        offs_out = stepping ? (offs_in + PHYS_W'(1)) : offs_in;
        vec_out  = stepping;
    end

    // Flag any nonzero element-width code.
    always_comb begin
        fault_out = |entry.ewidth;
    end
endmodule

// File: rtl/vreg_redirect.sv
// Module: top of the remapping unit. Holds one table per register file,
// routes the write to the selected table and resolves the lookup from the
// table chosen by lk_fp.
// Assumes callers sequence the loop offset; the lookup is single cycle.
module vreg_redirect
    import vrr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_fp,
    input  logic [4:0]        wr_addr,
    input  logic              wr_active,
    input  logic              wr_vector,
    input  logic [5:0]        wr_target,
    input  logic [1:0]        wr_ewidth,
    input  logic              lk_fp,
    input  logic [4:0]        lk_reg,
    input  logic [5:0]        lk_offs,
    output logic [5:0]        phys_reg,
    output logic [5:0]        offs_next,
    output logic              is_vec,
    output logic              elw_fault
);
    map_entry_t wr_data;
    map_entry_t bank_rd [FILE_CNT];
    map_entry_t sel_entry;

    // Pack the write fields into one entry.
    always_comb begin
        wr_data = '{active: wr_active, vector: wr_vector,
                    target: wr_target, ewidth: wr_ewidth};
    end

    // One table per register file, each written only when selected.
    for (genvar f = 0; f < FILE_CNT; f++) begin : g_bank
        vrr_entry_bank bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (int'(wr_fp) == f)),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (lk_reg),
            .rd_data (bank_rd[f])
        );
    end

    // Pick the entry from the table named by the lookup.
    always_comb begin
        sel_entry = bank_rd[lk_fp];
    end

    vrr_resolve resolve_i (
        .entry     (sel_entry),
        .arch_reg  (lk_reg),
        .offs_in   (lk_offs),
        .phys_out  (phys_reg),
        .offs_out  (offs_next),
        .vec_out   (is_vec),
        .fault_out (elw_fault)
    );

    // Disabled entry passes the number through with no vector flag.
    assert_inactive_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_entry.active |-> (phys_reg == {1'b0, lk_reg}) && !is_vec);

    // Non-vector results leave the offset untouched.
    assert_offs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_vec |-> (offs_next == lk_offs));

    // Vector results advance the offset by one, wrapping.
    assert_vector_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_vec |-> (offs_next == lk_offs + 6'd1));

    // Vector flag implies an enabled vector entry.
    assert_vec_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_vec |-> (sel_entry.active && sel_entry.vector));

    // Nonzero element width always faults.
    assert_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_entry.ewidth != '0) |-> elw_fault);
endmodule

// File: tb/vreg_redirect_tb_top.sv
// Bench: table-driven checks of the lookup, then directed reset, collision
// and independence tests.
module vreg_redirect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_fp = 1'b0, wr_active = 1'b0, wr_vector = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [5:0] wr_target = '0;
    logic [1:0] wr_ewidth = '0;
    logic       lk_fp = 1'b0;
    logic [4:0] lk_reg = '0;
    logic [5:0] lk_offs = '0;
    logic [5:0] phys_reg, offs_next;
    logic       is_vec, elw_fault;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vreg_redirect dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fp(wr_fp),
        .wr_addr(wr_addr), .wr_active(wr_active), .wr_vector(wr_vector),
        .wr_target(wr_target), .wr_ewidth(wr_ewidth), .lk_fp(lk_fp),
        .lk_reg(lk_reg), .lk_offs(lk_offs), .phys_reg(phys_reg),
        .offs_next(offs_next), .is_vec(is_vec), .elw_fault(elw_fault)
    );

    typedef struct packed {
        logic       wfp;
        logic [4:0] waddr;
        logic       act;
        logic       vec;
        logic [5:0] tgt;
        logic [1:0] ew;
        logic       lfp;
        logic [4:0] lreg;
        logic [5:0] loffs;
        logic [5:0] ephys;
        logic [5:0] eoffs;
        logic       evec;
        logic       efault;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 5'd5,  1'b0, 1'b0, 6'd35, 2'd0, 1'b0, 5'd5,  6'd3,  6'd5,  6'd3,  1'b0, 1'b0}, // R3
        '{1'b0, 5'd5,  1'b1, 1'b0, 6'd35, 2'd0, 1'b0, 5'd5,  6'd3,  6'd35, 6'd3,  1'b0, 1'b0}, // R4
        '{1'b0, 5'd5,  1'b1, 1'b1, 6'd35, 2'd0, 1'b0, 5'd5,  6'd3,  6'd38, 6'd4,  1'b1, 1'b0}, // R5 R6
        '{1'b1, 5'd5,  1'b1, 1'b1, 6'd10, 2'd0, 1'b1, 5'd5,  6'd0,  6'd10, 6'd1,  1'b1, 1'b0}, // R1
        '{1'b0, 5'd9,  1'b1, 1'b1, 6'd62, 2'd0, 1'b0, 5'd9,  6'd5,  6'd3,  6'd6,  1'b1, 1'b0}, // R8
        '{1'b0, 5'd2,  1'b1, 1'b0, 6'd40, 2'd1, 1'b0, 5'd2,  6'd7,  6'd40, 6'd7,  1'b0, 1'b1}, // R7
        '{1'b0, 5'd31, 1'b1, 1'b1, 6'd63, 2'd0, 1'b0, 5'd31, 6'd63, 6'd62, 6'd0,  1'b1, 1'b0}, // R8
        '{1'b1, 5'd0,  1'b1, 1'b0, 6'd63, 2'd0, 1'b1, 5'd0,  6'd9,  6'd63, 6'd9,  1'b0, 1'b0}  // R2
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [5:0] ep,
                             input logic [5:0] eo, input logic ev, input logic ef);
        check({req, " phys"},  phys_reg,  ep);
        check({req, " offs"},  offs_next, eo);
        check({req, " vec"},   is_vec,    ev);
        check({req, " fault"}, elw_fault, ef);
    endtask

    task automatic write_entry(input logic fp, input logic [4:0] a, input logic act,
                               input logic vec, input logic [5:0] t, input logic [1:0] e);
        @(negedge clk);
        wr_en = 1'b1; wr_fp = fp; wr_addr = a; wr_active = act;
        wr_vector = vec; wr_target = t; wr_ewidth = e;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic lookup(input logic fp, input logic [4:0] r, input logic [5:0] o);
        @(negedge clk);
        lk_fp = fp; lk_reg = r; lk_offs = o;
        #1;
    endtask

    initial begin : watchdog
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state: every entry passes through
        lookup(1'b0, 5'd7, 6'd9);
        check_all("R9 reset int", 6'd7, 6'd9, 1'b0, 1'b0);
        lookup(1'b1, 5'd31, 6'd2);
        check_all("R9 reset fp", 6'd31, 6'd2, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            write_entry(TBL[i].wfp, TBL[i].waddr, TBL[i].act, TBL[i].vec,
                        TBL[i].tgt, TBL[i].ew);
            lookup(TBL[i].lfp, TBL[i].lreg, TBL[i].loffs);
            check_all($sformatf("vector %0d", i), TBL[i].ephys, TBL[i].eoffs,
                      TBL[i].evec, TBL[i].efault);
        end

        // R1: the integer entry 5 is untouched by the fp write to entry 5
        lookup(1'b0, 5'd5, 6'd3);
        check_all("R1 int after fp write", 6'd38, 6'd4, 1'b1, 1'b0);

        // R7: a disabled entry with nonzero width still faults
        write_entry(1'b0, 5'd20, 1'b0, 1'b0, 6'd0, 2'd3);
        lookup(1'b0, 5'd20, 6'd1);
        check_all("R7 inactive fault", 6'd20, 6'd1, 1'b0, 1'b1);

        // R10: same-cycle write and lookup of integer entry 12
        @(negedge clk);
        wr_en = 1'b1; wr_fp = 1'b0; wr_addr = 5'd12; wr_active = 1'b1;
        wr_vector = 1'b0; wr_target = 6'd50; wr_ewidth = 2'd0;
        lk_fp = 1'b0; lk_reg = 5'd12; lk_offs = 6'd4;
        #1 check("R10 old value before edge", phys_reg, 12);
        @(posedge clk);
        #1 wr_en = 1'b0;
        check("R10 new value after edge", phys_reg, 50);

        // R1: a write to fp entry 12 while integer entry 12 is read
        @(negedge clk);
        wr_en = 1'b1; wr_fp = 1'b1; wr_addr = 5'd12; wr_active = 1'b1;
        wr_vector = 1'b1; wr_target = 6'd1; wr_ewidth = 2'd2;
        @(posedge clk);
        #1 wr_en = 1'b0;
        check_all("R1 cross-table collision", 6'd50, 6'd4, 1'b0, 1'b0);

        // R9: reset clears the enabled entries again
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        lookup(1'b0, 5'd5, 6'd3);
        check_all("R9 reset clears int", 6'd5, 6'd3, 1'b0, 1'b0);
        lookup(1'b1, 5'd0, 6'd3);
        check_all("R9 reset clears fp", 6'd0, 6'd3, 1'b0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule